// File: doc/BRIEF.md
# Power-Mode Step Sequencer

This block carries a processor through a power-mode change as a fixed series of sixteen steps. A sleep request with a non-run target walks the first eight steps in ascending order. Once the sequence is asleep, a wakeup event walks the last eight steps, which undo the sleep steps in reverse. At each step the sequencer raises a one-hot request toward the hardware that performs that step. The step then finishes under its own completion policy: wait for the done response, wait for done and then a programmed delay, run the counter only, or take whichever of done and the counter comes first.

The two steps on each side of the sleep/wake boundary belong to the setpoint and standby controllers. The sequencer drives dedicated request outputs for them and takes their done responses from dedicated inputs. A step whose enable bit is clear raises no request and is passed over. The block tracks the current and previous power mode and reports separate busy flags for the two directions. It can also hold the core asleep from sleep entry until the wakeup sequence has ended. A wakeup event that arrives during the sleep sequence is remembered, and it turns the sequence around as soon as the running step finishes.

Top module: `pwr_step_seq`

## Requirements
- R1: A sleep request (`sleep_req_i` high while idle, `target_mode_i` not 0) runs steps 0..7 in ascending order. At most one bit of `step_req_o` is high at a time, and bit s is high while step s is in progress.
- R2: A wakeup event while asleep runs steps 8..15 in ascending order.
- R3: Counter mode 0 (bits [2s+1:2s] of `step_mode_i` = 0): D is the number of cycles of the request before done is first sampled high. The request is then high for D+1 cycles, and the count field has no effect.
- R4: Counter mode 1: the request is high for D+N+2 cycles, where N is bits [16s+15:16s] of `step_cnt_i`. The N+1 cycles after the done cycle are the delay, so N = 0 finishes on the next cycle.
- R5: Counter mode 2: done is ignored and the request is high for N+1 cycles.
- R6: Counter mode 3: the request is high for min(D,N)+1 cycles.
- R7: A step whose `step_en_i` bit is 0 never raises its request and takes exactly one cycle of its sequence.
- R8: Steps 6 and 9 complete on `sp_done_i` and steps 7 and 8 complete on `stby_done_i`. Bits 6..9 of `step_done_i` are ignored. `sp_req_o` is high exactly when step 6 or 9 is requested, and `stby_req_o` exactly when step 7 or 8 is requested.
- R9: Modes are encoded 0 run, 1 wait, 2 stop, 3 suspend. At the end of sleep the current mode becomes the target and the previous mode becomes run. At the end of wakeup the current mode becomes run and the previous mode becomes the mode that was left. A sleep request with target 0, a sleep request while asleep, and a wakeup event while idle are all ignored.
- R10: `sleep_busy_o` is high for every cycle of steps 0..7 and `wake_busy_o` for every cycle of steps 8..15. The two flags are never high together.
- R11: A wakeup event during the sleep sequence lets the running step finish, then jumps to step 8. No later sleep step is requested and the current mode stays run.
- R12: If `sleep_hold_en_i` is high when sleep starts, `core_hold_o` is high from the first sleep step until the last wakeup step ends. Otherwise it stays low.
- R13: After reset all requests and flags are low and both modes read run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req_i | input | 1 | Start a sleep sequence |
| target_mode_i | input | 2 | Mode to enter at the end of sleep |
| sleep_hold_en_i | input | 1 | Hold the core across the whole sleep/wake cycle |
| wake_evt_i | input | 1 | Wakeup event |
| step_en_i | input | 16 | Per-step enable |
| step_mode_i | input | 32 | Per-step counter mode, 2 bits per step |
| step_cnt_i | input | 256 | Per-step count, 16 bits per step |
| step_done_i | input | 16 | Per-step done from local step hardware |
| sp_done_i | input | 1 | Done from the setpoint controller |
| stby_done_i | input | 1 | Done from the standby controller |
| step_req_o | output | 16 | One-hot step request |
| sp_req_o | output | 1 | Request to the setpoint controller |
| stby_req_o | output | 1 | Request to the standby controller |
| sleep_busy_o | output | 1 | Sleep sequence in progress |
| wake_busy_o | output | 1 | Wakeup sequence in progress |
| core_hold_o | output | 1 | Core held in sleep |
| cur_mode_o | output | 2 | Current power mode |
| prev_mode_o | output | 2 | Previous power mode |

## Verification
The bench sweeps every counter mode across all sixteen steps, with response delays and counts that include zero. It also mixes modes with disabled steps, and compares every request width and the total busy time against the arithmetic of R3 to R7. An off-by-one in the delay or count compare would show up as a width one cycle wrong, and a skipped step that still cost its full time would inflate the busy count. Bits 6..9 of the local done vector are held high all the time, so a design that took the setpoint or standby done from the wrong source would finish those steps early. An early wakeup is injected in the middle of step 2: a design that dropped the latched event would run the remaining sleep steps and change mode, and one that cut the running step short would shorten its request.

// File: rtl/pwr_step_pkg.sv
`timescale 1ns/1ps
package pwr_step_pkg;
  // Completion policy of one step
  typedef enum logic [1:0] {
    CM_DONE  = 2'd0,  // finish on done
    CM_DELAY = 2'd1,  // done, then count
    CM_COUNT = 2'd2,  // count only
    CM_FIRST = 2'd3   // earlier of done and count
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_RUN    = 2'd1,
    SQ_ASLEEP = 2'd2
  } seq_state_e;

  localparam logic [1:0] MODE_RUN = 2'd0;
endpackage

// File: rtl/pwr_step_done_route.sv
`timescale 1ns/1ps
module pwr_step_done_route #(
  parameter int NUM_STEPS = 16
) (
  input  logic [NUM_STEPS-1:0] step_done_i,
  input  logic                 sp_done_i,
  input  logic                 stby_done_i,
  output logic [NUM_STEPS-1:0] done_o
);
  localparam int HALF = NUM_STEPS / 2;

  // local done lines at the hand-off positions are not used
  logic handoff_unused;
  assign handoff_unused = ^step_done_i[HALF+1:HALF-2];

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_route
    if (g == HALF - 2 || g == HALF + 1) begin : g_sp
      assign done_o[g] = sp_done_i;
    end else if (g == HALF - 1 || g == HALF) begin : g_stby
      assign done_o[g] = stby_done_i;
    end else begin : g_local
      assign done_o[g] = step_done_i[g];
    end
  end
endmodule

// File: rtl/pwr_step_timer.sv
`timescale 1ns/1ps
module pwr_step_timer
  import pwr_step_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             done_i,
  input  cnt_mode_e        mode_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             fin_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dly_q;
  logic             hit;
  logic             fin;

  assign hit = (cnt_q == limit_i);

  always_comb begin
    case (mode_i)
      CM_DONE:  fin = done_i;
      CM_DELAY: fin = dly_q && hit;
      CM_COUNT: fin = hit;
      default:  fin = done_i || hit;
    endcase
  end

  assign fin_o = run_i && fin;

  always_ff @(posedge clk) begin
    if (rst || !run_i || fin_o) begin
      cnt_q <= '0;
      dly_q <= 1'b0;
    end else begin
      case (mode_i)
        CM_DELAY: begin
          if (!dly_q) dly_q <= done_i;
          else        cnt_q <= cnt_q + CNT_W'(1);
        end
        CM_COUNT, CM_FIRST: cnt_q <= cnt_q + CNT_W'(1);
        default: ;
      endcase
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && mode_i == CM_COUNT) |-> (cnt_q <= limit_i));
endmodule

// File: rtl/pwr_mode_track.sv
`timescale 1ns/1ps
module pwr_mode_track
  import pwr_step_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_fin_i,
  input  logic       wake_fin_i,
  input  logic [1:0] tgt_i,
  output logic [1:0] cur_o,
  output logic [1:0] prev_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_o  <= MODE_RUN;
      prev_o <= MODE_RUN;
    end else if (sleep_fin_i) begin
      prev_o <= cur_o;
      cur_o  <= tgt_i;
    end else if (wake_fin_i && cur_o != MODE_RUN) begin
      prev_o <= cur_o;
      cur_o  <= MODE_RUN;
    end
  end

  // R9
  mode_enter_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_fin_i |=> (cur_o == $past(tgt_i) && prev_o == $past(cur_o)));
  // R9
  mode_leave_chk: assert property (@(posedge clk) disable iff (rst)
    wake_fin_i |=> (cur_o == MODE_RUN));
endmodule

// File: rtl/pwr_step_seq.sv
`timescale 1ns/1ps
module pwr_step_seq
  import pwr_step_pkg::*;
#(
  parameter int NUM_STEPS = 16,
  parameter int CNT_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sleep_req_i,
  input  logic [1:0]                 target_mode_i,
  input  logic                       sleep_hold_en_i,
  input  logic                       wake_evt_i,
  input  logic [NUM_STEPS-1:0]       step_en_i,
  input  logic [2*NUM_STEPS-1:0]     step_mode_i,
  input  logic [CNT_W*NUM_STEPS-1:0] step_cnt_i,
  input  logic [NUM_STEPS-1:0]       step_done_i,
  input  logic                       sp_done_i,
  input  logic                       stby_done_i,
  output logic [NUM_STEPS-1:0]       step_req_o,
  output logic                       sp_req_o,
  output logic                       stby_req_o,
  output logic                       sleep_busy_o,
  output logic                       wake_busy_o,
  output logic                       core_hold_o,
  output logic [1:0]                 cur_mode_o,
  output logic [1:0]                 prev_mode_o
);
  localparam int HALF       = NUM_STEPS / 2;
  localparam int IDX_W      = $clog2(NUM_STEPS);
  localparam int SP_SLEEP   = HALF - 2;
  localparam int STBY_SLEEP = HALF - 1;
  localparam int STBY_WAKE  = HALF;
  localparam int SP_WAKE    = HALF + 1;
  localparam logic [IDX_W-1:0] IDX_SLEEP_LAST = IDX_W'(HALF - 1);
  localparam logic [IDX_W-1:0] IDX_WAKE_FIRST = IDX_W'(HALF);
  localparam logic [IDX_W-1:0] IDX_LAST       = IDX_W'(NUM_STEPS - 1);

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pend_q, pend_d;
  logic [1:0]       tgt_q, tgt_d;
  logic             hold_en_q, hold_en_d;
  logic [NUM_STEPS-1:0] done_rt;
  logic [NUM_STEPS-1:0] req_d;
  logic             step_on, adv, in_sleep, wake_now;
  logic             sleep_fin, wake_fin, tmr_fin;
  cnt_mode_e        mode_sel;
  logic [CNT_W-1:0] limit_sel;

  pwr_step_done_route #(.NUM_STEPS(NUM_STEPS)) route_i (
    .step_done_i (step_done_i),
    .sp_done_i   (sp_done_i),
    .stby_done_i (stby_done_i),
    .done_o      (done_rt)
  );

  assign mode_sel  = cnt_mode_e'(step_mode_i[int'(idx_q)*2 +: 2]);
  assign limit_sel = step_cnt_i[int'(idx_q)*CNT_W +: CNT_W];
  assign step_on   = (st_q == SQ_RUN) && step_en_i[idx_q];
  assign adv       = (st_q == SQ_RUN) && (!step_en_i[idx_q] || tmr_fin);
  assign in_sleep  = (idx_q < IDX_WAKE_FIRST);
  assign wake_now  = pend_q || wake_evt_i;

  pwr_step_timer #(.CNT_W(CNT_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .run_i   (step_on),
    .done_i  (done_rt[idx_q]),
    .mode_i  (mode_sel),
    .limit_i (limit_sel),
    .fin_o   (tmr_fin)
  );

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    pend_d    = pend_q;
    tgt_d     = tgt_q;
    hold_en_d = hold_en_q;
    sleep_fin = 1'b0;
    wake_fin  = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (sleep_req_i && target_mode_i != MODE_RUN) begin
          st_d      = SQ_RUN;
          idx_d     = '0;
          pend_d    = 1'b0;
          tgt_d     = target_mode_i;
          hold_en_d = sleep_hold_en_i;
        end
      end
      SQ_ASLEEP: begin
        if (wake_evt_i) begin
          st_d  = SQ_RUN;
          idx_d = IDX_WAKE_FIRST;
        end
      end
      default: begin
        if (in_sleep && wake_evt_i) pend_d = 1'b1;
        if (adv) begin
          if (in_sleep && wake_now) begin
            idx_d  = IDX_WAKE_FIRST;
            pend_d = 1'b0;
          end else if (idx_q == IDX_SLEEP_LAST) begin
            st_d      = SQ_ASLEEP;
            sleep_fin = 1'b1;
          end else if (idx_q == IDX_LAST) begin
            st_d     = SQ_IDLE;
            wake_fin = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
    endcase
  end

  always_comb begin
    req_d = '0;
    if (st_d == SQ_RUN && step_en_i[idx_d]) req_d[idx_d] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= SQ_IDLE;
      idx_q        <= '0;
      pend_q       <= 1'b0;
      tgt_q        <= MODE_RUN;
      hold_en_q    <= 1'b0;
      step_req_o   <= '0;
      sp_req_o     <= 1'b0;
      stby_req_o   <= 1'b0;
      sleep_busy_o <= 1'b0;
      wake_busy_o  <= 1'b0;
      core_hold_o  <= 1'b0;
    end else begin
      st_q         <= st_d;
      idx_q        <= idx_d;
      pend_q       <= pend_d;
      tgt_q        <= tgt_d;
      hold_en_q    <= hold_en_d;
      step_req_o   <= req_d;
      sp_req_o     <= req_d[SP_SLEEP] || req_d[SP_WAKE];
      stby_req_o   <= req_d[STBY_SLEEP] || req_d[STBY_WAKE];
      sleep_busy_o <= (st_d == SQ_RUN) && (idx_d < IDX_WAKE_FIRST);
      wake_busy_o  <= (st_d == SQ_RUN) && (idx_d >= IDX_WAKE_FIRST);
      core_hold_o  <= hold_en_d && (st_d != SQ_IDLE);
    end
  end

  pwr_mode_track mode_i (
    .clk         (clk),
    .rst         (rst),
    .sleep_fin_i (sleep_fin),
    .wake_fin_i  (wake_fin),
    .tgt_i       (tgt_q),
    .cur_o       (cur_mode_o),
    .prev_o      (prev_mode_o)
  );

  // R1
  rq_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_req_o));
  // R1
  sleep_order_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_busy_o && $past(sleep_busy_o)) |-> (idx_q >= $past(idx_q)));
  // R10
  busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sleep_busy_o && wake_busy_o));
  // R8
  handoff_chk: assert property (@(posedge clk) disable iff (rst)
    sp_req_o |-> (step_req_o[SP_SLEEP] || step_req_o[SP_WAKE]));
  // R9
  mode_change_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_mode_o != $past(cur_mode_o)) |-> (!sleep_busy_o && !wake_busy_o));
  // R11
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_busy_o && !$past(wake_busy_o) && $past(sleep_busy_o)) |-> (cur_mode_o == MODE_RUN));
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    core_hold_o |-> (sleep_busy_o || wake_busy_o || cur_mode_o != MODE_RUN));
endmodule

// File: tb/pwr_step_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_step_seq_tb_top;
  localparam int NS = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req_i = 1'b0;
  logic [1:0] target_mode_i = 2'd0;
  logic sleep_hold_en_i = 1'b0;
  logic wake_evt_i = 1'b0;
  logic [NS-1:0] step_en_i = '1;
  logic [2*NS-1:0] step_mode_i = '0;
  logic [CW*NS-1:0] step_cnt_i = '0;
  logic [NS-1:0] step_done_i = '0;
  logic sp_done_i = 1'b0;
  logic stby_done_i = 1'b0;
  logic [NS-1:0] step_req_o;
  logic sp_req_o, stby_req_o, sleep_busy_o, wake_busy_o, core_hold_o;
  logic [1:0] cur_mode_o, prev_mode_o;

  pwr_step_seq #(.NUM_STEPS(NS), .CNT_W(CW)) dut_i (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  int cfg_m[NS], cfg_d[NS], cfg_n[NS];
  bit cfg_e[NS];
  bit hold_cfg = 1'b0;

  int kk[NS], wid[NS], rise_ord[NS];
  int ord_ctr, sl_cnt, wk_cnt, ho_bad, hold_bad, hold_cnt;
  logic [NS-1:0] dv;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // responder and monitor, all at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int s = 0; s < NS; s++) begin
        if (step_req_o[s]) begin
          if (kk[s] == 0) begin
            rise_ord[s] = ord_ctr;
            ord_ctr++;
          end
          dv[s] = (kk[s] >= cfg_d[s]);
          wid[s]++;
          kk[s]++;
        end else begin
          kk[s] = 0;
          dv[s] = 1'b0;
        end
      end
      // R8: local done bits 6..9 forced high, must be ignored
      step_done_i = dv | 16'h03C0;
      sp_done_i   = dv[6] | dv[9];
      stby_done_i = dv[7] | dv[8];
      if (sleep_busy_o) sl_cnt++;
      if (wake_busy_o)  wk_cnt++;
      if (sp_req_o != (step_req_o[6] | step_req_o[9]) ||
          stby_req_o != (step_req_o[7] | step_req_o[8])) ho_bad++;
      if (core_hold_o != (hold_cfg && (sleep_busy_o || wake_busy_o || cur_mode_o != 2'd0)))
        hold_bad++;
      if (core_hold_o) hold_cnt++;
    end
  end

  task automatic clr_stats();
    @(posedge clk);
    #1;
    for (int s = 0; s < NS; s++) begin
      wid[s] = 0;
      rise_ord[s] = -1;
    end
    ord_ctr = 0; sl_cnt = 0; wk_cnt = 0; ho_bad = 0; hold_bad = 0; hold_cnt = 0;
  endtask

  task automatic apply_cfg();
    for (int s = 0; s < NS; s++) begin
      step_en_i[s] = cfg_e[s];
      step_mode_i[2*s +: 2] = 2'(cfg_m[s]);
      step_cnt_i[CW*s +: CW] = CW'(cfg_n[s]);
    end
  endtask

  function automatic int exp_w(int s);
    if (!cfg_e[s]) return 0;
    case (cfg_m[s])
      0: return cfg_d[s] + 1;
      1: return cfg_d[s] + cfg_n[s] + 2;
      2: return cfg_n[s] + 1;
      default: return ((cfg_d[s] < cfg_n[s]) ? cfg_d[s] : cfg_n[s]) + 1;
    endcase
  endfunction

  function automatic int cost(int s);
    return cfg_e[s] ? exp_w(s) : 1;
  endfunction

  function automatic string tag_of(int s);
    if (!cfg_e[s]) return "R7";
    case (cfg_m[s])
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_half(int lo, string ord_tag, string busy_tag, int busy_act);
    int prev_o = -1;
    bit ord_ok = 1'b1;
    int sum = 0;
    for (int s = lo; s < lo + NS/2; s++) begin
      chk(wid[s] == exp_w(s), tag_of(s), $sformatf("step %0d request width", s), wid[s], exp_w(s));
      sum += cost(s);
      if (wid[s] > 0) begin
        if (rise_ord[s] <= prev_o) ord_ok = 1'b0;
        prev_o = rise_ord[s];
      end
    end
    chk(ord_ok, ord_tag, "ascending step order", int'(ord_ok), 1);
    chk(busy_act == sum, busy_tag, "busy cycle total", busy_act, sum);
  endtask

  task automatic run_full(int tgt, bit hold);
    clr_stats();
    hold_cfg = hold;
    sleep_hold_en_i = hold;
    @(negedge clk);
    target_mode_i = 2'(tgt);
    sleep_req_i = 1'b1;
    @(negedge clk);
    sleep_req_i = 1'b0;
    while (sleep_busy_o) @(negedge clk);
    check_half(0, "R1", "R10", sl_cnt);
    chk(cur_mode_o == 2'(tgt), "R9", "mode after sleep", cur_mode_o, tgt);
    chk(prev_mode_o == 2'd0, "R9", "previous mode after sleep", prev_mode_o, 0);
    @(negedge clk);
    wake_evt_i = 1'b1;
    @(negedge clk);
    wake_evt_i = 1'b0;
    while (wake_busy_o) @(negedge clk);
    check_half(NS/2, "R2", "R10", wk_cnt);
    chk(cur_mode_o == 2'd0, "R9", "mode after wakeup", cur_mode_o, 0);
    chk(prev_mode_o == 2'(tgt), "R9", "previous mode after wakeup", prev_mode_o, tgt);
    chk(ho_bad == 0, "R8", "hand-off request mismatches", ho_bad, 0);
    chk(hold_bad == 0, "R12", "core hold mismatches", hold_bad, 0);
    chk((hold_cnt > 0) == hold, "R12", "core hold seen", int'(hold_cnt > 0), int'(hold));
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      kk[s] = 0; wid[s] = 0; rise_ord[s] = -1;
      cfg_m[s] = 0; cfg_d[s] = 0; cfg_n[s] = 0; cfg_e[s] = 1'b1;
    end
    dv = '0;
    ord_ctr = 0; sl_cnt = 0; wk_cnt = 0; ho_bad = 0; hold_bad = 0; hold_cnt = 0;
    apply_cfg();
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R13: reset state
    chk(step_req_o == '0, "R13", "requests after reset", int'(step_req_o), 0);
    chk(!sleep_busy_o && !wake_busy_o && !core_hold_o, "R13", "flags after reset",
        int'({sleep_busy_o, wake_busy_o, core_hold_o}), 0);
    chk(cur_mode_o == 2'd0 && prev_mode_o == 2'd0, "R13", "modes after reset",
        int'({cur_mode_o, prev_mode_o}), 0);

    // one counter mode on every step
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < NS; s++) begin
        cfg_m[s] = m;
        cfg_d[s] = (s * 3 + m) % 5;
        cfg_n[s] = (s + m) % 4;
        cfg_e[s] = 1'b1;
      end
      apply_cfg();
      run_full(m % 3 + 1, m[0]);
    end

    // mixed modes with disabled steps
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < NS; s++) begin
        cfg_m[s] = (s + c) % 4;
        cfg_d[s] = (s * 3 + c) % 5;
        cfg_n[s] = (s * 7 + c) % 5;
        cfg_e[s] = ((s + c) % 3) != 0;
      end
      apply_cfg();
      run_full(c % 3 + 1, !c[0]);
    end

    // R11: wakeup latched during step 2
    for (int s = 0; s < NS; s++) begin
      cfg_m[s] = 2; cfg_d[s] = 1; cfg_n[s] = 3; cfg_e[s] = 1'b1;
    end
    apply_cfg();
    begin
      int prev_before;
      int sum_w = 0;
      prev_before = int'(prev_mode_o);
      clr_stats();
      hold_cfg = 1'b0;
      sleep_hold_en_i = 1'b0;
      @(negedge clk);
      target_mode_i = 2'd2;
      sleep_req_i = 1'b1;
      @(negedge clk);
      sleep_req_i = 1'b0;
      while (!step_req_o[2]) @(negedge clk);
      wake_evt_i = 1'b1;
      @(negedge clk);
      wake_evt_i = 1'b0;
      while (sleep_busy_o || wake_busy_o) @(negedge clk);
      chk(wid[2] == exp_w(2), "R11", "running step keeps its width", wid[2], exp_w(2));
      for (int s = 3; s < NS/2; s++)
        chk(wid[s] == 0, "R11", $sformatf("sleep step %0d skipped after wake", s), wid[s], 0);
      for (int s = NS/2; s < NS; s++) sum_w += cost(s);
      chk(wk_cnt == sum_w, "R11", "full wakeup sequence busy total", wk_cnt, sum_w);
      chk(wid[15] == exp_w(15), "R11", "last wakeup step runs", wid[15], exp_w(15));
      chk(cur_mode_o == 2'd0, "R11", "mode stays run", cur_mode_o, 0);
      chk(int'(prev_mode_o) == prev_before, "R11", "previous mode unchanged", prev_mode_o, prev_before);
    end

    // R9: ignored stimuli
    clr_stats();
    @(negedge clk);
    target_mode_i = 2'd0;
    sleep_req_i = 1'b1;
    @(negedge clk);
    sleep_req_i = 1'b0;
    wake_evt_i = 1'b1;
    @(negedge clk);
    wake_evt_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(sl_cnt == 0 && wk_cnt == 0, "R9", "run target and idle wakeup ignored", sl_cnt + wk_cnt, 0);
    chk(cur_mode_o == 2'd0, "R9", "mode unchanged by ignored requests", cur_mode_o, 0);

    clr_stats();
    @(negedge clk);
    target_mode_i = 2'd3;
    sleep_req_i = 1'b1;
    @(negedge clk);
    sleep_req_i = 1'b0;
    while (sleep_busy_o) @(negedge clk);
    chk(cur_mode_o == 2'd3, "R9", "suspend entered", cur_mode_o, 3);
    sl_cnt = 0;
    target_mode_i = 2'd1;
    sleep_req_i = 1'b1;
    @(negedge clk);
    sleep_req_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(sl_cnt == 0, "R9", "sleep request while asleep ignored", sl_cnt, 0);
    chk(cur_mode_o == 2'd3, "R9", "mode kept while asleep", cur_mode_o, 3);
    wake_evt_i = 1'b1;
    @(negedge clk);
    wake_evt_i = 1'b0;
    while (wake_busy_o) @(negedge clk);
    chk(cur_mode_o == 2'd0 && prev_mode_o == 2'd3, "R9", "return to run from suspend",
        int'({cur_mode_o, prev_mode_o}), 3);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule